// File: doc/BRIEF.md
# Windowed Next-PC and Return-Link Generator

This block computes the next instruction fetch address for a small processor whose instruction store occupies a 4 KB window at a fixed base address. Each cycle it receives the current PC, a two-bit control-flow selector, the instruction-index and offset immediates, and a register operand. It forms a 12-bit window offset for the selected flow type and merges that offset onto the window base. As a result, every address it produces lands inside the window, whatever the inputs.

When the selected flow also asks for a link, the block produces a write request for the register file in the same cycle as the target. The request carries the destination register index and the return address, which is the current PC plus 4. All outputs come from registers, so they show the inputs sampled at the previous rising clock edge. Branch condition evaluation, delay-slot handling and the fetch itself take place outside this block.

Top module: `pcwin_nextpc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `next_pc` is 0x04001000 and `link_we` is 0.
- R2: Bits 31:12 of `next_pc` always equal bits 31:12 of the window base 0x04001000. Bits 31:12 of `cur_pc` and `reg_val` never reach `next_pc`.
- R3: When `flow` is 0 (sequential), the low 12 bits of `next_pc` are (`cur_pc` + 4) modulo 4096, so 0x04001FFC is followed by 0x04001000.
- R4: When `flow` is 1 (absolute), the low 12 bits of `next_pc` are (`imm_index` << 2) & 0xFFF.
- R5: When `flow` is 2 (relative), the low 12 bits of `next_pc` are (`cur_pc` + sign-extended `imm_offset` × 4) & 0xFFF. A negative offset wraps to the top of the window.
- R6: When `flow` is 3 (register), the low 12 bits of `next_pc` are `reg_val` & 0xFFF.
- R7: When `do_link` is 1 and `flow` is not 0, `link_we` is 1, `link_idx` equals `link_sel`, and `link_val` is the full 32-bit `cur_pc` + 4 with no wrapping. In every other case `link_we` is 0.
- R8: Each output reflects the inputs sampled at the previous rising edge of `clk`, through exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction being resolved |
| flow | input | 2 | Flow type: 0 sequential, 1 absolute, 2 relative, 3 register |
| do_link | input | 1 | Request a return-address write |
| link_sel | input | 5 | Destination register for the return address |
| imm_index | input | 26 | Instruction-index immediate for absolute jumps |
| imm_offset | input | 16 | Signed word offset for relative branches |
| reg_val | input | 32 | Register operand for indirect jumps |
| next_pc | output | 32 | Registered next fetch address |
| link_we | output | 1 | Registered return-address write enable |
| link_idx | output | 5 | Registered destination register index |
| link_val | output | 32 | Registered return address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 12-bit window offset, the base 0x04001000, a 26-bit index, a 16-bit offset, and the unwrapped link option. With the window this small, a handful of directed values reaches every wrap point. These include a sequential step off 0x04001FFC, a negative relative offset taken from the window base, and an all-ones index. They also include register and PC values whose upper bits are full of noise, which must not leak into the target. Random traffic then mixes all four flow codes, with and without a link request, against a behavioural model that is compared on every cycle.

// File: rtl/pcwin_pkg.sv
package pcwin_pkg;
   typedef enum logic [1:0] {
      FLOW_SEQ = 2'd0,
      FLOW_ABS = 2'd1,
      FLOW_REL = 2'd2,
      FLOW_REG = 2'd3
   } flow_e;
endpackage

// File: rtl/pcwin_target.sv
module pcwin_target
   import pcwin_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 12,
   parameter int IDX_W   = 26,
   parameter int OFF_W   = 16,
   parameter int WSHIFT  = 2,
   parameter int STEP    = 4
) (
   input  logic [1:0]        flow,
   input  logic [OFS_W-1:0]  cur_ofs,
   input  logic [IDX_W-1:0]  imm_index,
   input  logic [OFF_W-1:0]  imm_offset,
   input  logic [OFS_W-1:0]  reg_ofs,
   output logic [OFS_W-1:0]  tgt_ofs
);
   localparam int SX_W = ADDR_W;

   logic [SX_W-1:0]  off_sx;
   logic [SX_W-1:0]  off_sh;
   logic [SX_W-1:0]  idx_sh;
   logic [OFS_W-1:0] seq_ofs;
   logic [OFS_W-1:0] rel_ofs;
   logic [OFS_W-1:0] abs_ofs;

   always_comb begin
      off_sx  = {{(SX_W-OFF_W){imm_offset[OFF_W-1]}}, imm_offset};
      off_sh  = off_sx << WSHIFT;
      idx_sh  = {{(SX_W-IDX_W){1'b0}}, imm_index} << WSHIFT;
      seq_ofs = cur_ofs + OFS_W'(STEP);
      rel_ofs = cur_ofs + off_sh[OFS_W-1:0];
      abs_ofs = idx_sh[OFS_W-1:0];
   end

   always_comb begin
      unique case (flow_e'(flow))
         FLOW_ABS: tgt_ofs = abs_ofs;
         FLOW_REL: tgt_ofs = rel_ofs;
         FLOW_REG: tgt_ofs = reg_ofs;
         default:  tgt_ofs = seq_ofs;
      endcase
   end
endmodule

// File: rtl/pcwin_link.sv
module pcwin_link
   import pcwin_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          OFS_W     = 12,
   parameter logic [31:0] BASE      = 32'h0400_1000,
   parameter int          STEP      = 4,
   parameter bit          LINK_WRAP = 1'b0
) (
   input  logic [1:0]        flow,
   input  logic              do_link,
   input  logic [ADDR_W-1:0] cur_pc,
   output logic              we,
   output logic [ADDR_W-1:0] ret_addr
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI_MSK = ~((ADDR_W'(1) << OFS_W) - ADDR_W'(1));

   logic [ADDR_W-1:0] raw_ret;

   assign raw_ret = cur_pc + ADDR_W'(STEP);
   assign we      = do_link && (flow_e'(flow) != FLOW_SEQ);

   generate
      if (LINK_WRAP) begin : g_wrap
         assign ret_addr = (BASE_A & HI_MSK) | (raw_ret & ~HI_MSK);
      end else begin : g_raw
         assign ret_addr = raw_ret;
      end
   endgenerate
endmodule

// File: rtl/pcwin_nextpc.sv
module pcwin_nextpc
   import pcwin_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          OFS_W     = 12,
   parameter logic [31:0] BASE      = 32'h0400_1000,
   parameter int          IDX_W     = 26,
   parameter int          OFF_W     = 16,
   parameter int          RIDX_W    = 5,
   parameter int          WSHIFT    = 2,
   parameter int          STEP      = 4,
   parameter bit          LINK_WRAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cur_pc,
   input  logic [1:0]        flow,
   input  logic              do_link,
   input  logic [4:0]        link_sel,
   input  logic [25:0]       imm_index,
   input  logic [15:0]       imm_offset,
   input  logic [31:0]       reg_val,
   output logic [31:0]       next_pc,
   output logic              link_we,
   output logic [4:0]        link_idx,
   output logic [31:0]       link_val
);
   localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);
   localparam int                HI_W     = ADDR_W - OFS_W;
   localparam logic [HI_W-1:0]   BASE_HI  = BASE_A[ADDR_W-1:OFS_W];

   generate
      if (ADDR_W != 32)               begin : g_bad_aw  $error("ADDR_W must be 32"); end
      if (IDX_W != 26 || OFF_W != 16) begin : g_bad_imm $error("immediate widths fixed by ports"); end
      if (RIDX_W != 5)                begin : g_bad_ri  $error("RIDX_W must be 5"); end
      if (OFS_W < 3 || OFS_W >= ADDR_W) begin : g_bad_ow $error("OFS_W out of range"); end
      if (BASE_A[OFS_W-1:0] != '0)    begin : g_bad_bs  $error("BASE not aligned to window"); end
      if (STEP <= 0 || (STEP % (1 << WSHIFT)) != 0) begin : g_bad_st $error("STEP misaligned"); end
   endgenerate

   logic [OFS_W-1:0]  tgt_ofs;
   logic              lk_we;
   logic [ADDR_W-1:0] lk_val;

   pcwin_target #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W),
      .WSHIFT (WSHIFT),
      .STEP   (STEP)
   ) u_target (
      .flow       (flow),
      .cur_ofs    (cur_pc[OFS_W-1:0]),
      .imm_index  (imm_index),
      .imm_offset (imm_offset),
      .reg_ofs    (reg_val[OFS_W-1:0]),
      .tgt_ofs    (tgt_ofs)
   );

   pcwin_link #(
      .ADDR_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .BASE      (BASE),
      .STEP      (STEP),
      .LINK_WRAP (LINK_WRAP)
   ) u_link (
      .flow     (flow),
      .do_link  (do_link),
      .cur_pc   (cur_pc),
      .we       (lk_we),
      .ret_addr (lk_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc  <= BASE_A;
         link_we  <= 1'b0;
         link_idx <= '0;
         link_val <= '0;
      end else begin
         next_pc  <= {BASE_HI, tgt_ofs};
         link_we  <= lk_we;
         link_idx <= link_sel;
         link_val <= lk_val;
      end
   end
endmodule

// File: rtl/pcwin_nextpc_chk.sv
module pcwin_nextpc_chk #(
   parameter int          OFS_W = 12,
   parameter logic [31:0] BASE  = 32'h0400_1000
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cur_pc,
   input logic [1:0]  flow,
   input logic        do_link,
   input logic [4:0]  link_sel,
   input logic [25:0] imm_index,
   input logic [15:0] imm_offset,
   input logic [31:0] reg_val,
   input logic [31:0] next_pc,
   input logic        link_we,
   input logic [4:0]  link_idx,
   input logic [31:0] link_val
);
   // R2
   window_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc[31:OFS_W] == BASE[31:OFS_W]);

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow == 2'd0) |=> next_pc[OFS_W-1:0] == OFS_W'($past(cur_pc[OFS_W-1:0]) + OFS_W'(4)));

   // R6
   reg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow == 2'd3) |=> next_pc[OFS_W-1:0] == $past(reg_val[OFS_W-1:0]));

   // R7
   link_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_link && flow != 2'd0) |=> (link_we && link_val == $past(cur_pc) + 32'd4
                                     && link_idx == $past(link_sel)));

   // R7
   no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_link || flow == 2'd0) |=> !link_we);
endmodule

bind pcwin_nextpc pcwin_nextpc_chk #(.OFS_W(OFS_W), .BASE(BASE)) u_chk (.*);

// File: tb/pcwin_nextpc_tb.sv
`timescale 1ns/1ps
module pcwin_nextpc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0;
   logic [1:0]  flow = '0;
   logic        do_link = 1'b0;
   logic [4:0]  link_sel = '0;
   logic [25:0] imm_index = '0;
   logic [15:0] imm_offset = '0;
   logic [31:0] reg_val = '0;
   logic [31:0] next_pc;
   logic        link_we;
   logic [4:0]  link_idx;
   logic [31:0] link_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // expected outputs for the coming edge
   logic [31:0] e_pc;
   logic        e_we;
   logic [4:0]  e_idx;
   logic [31:0] e_val;

   always #5 clk = ~clk;

   pcwin_nextpc u_dut (.*);

   function automatic logic [31:0] model_pc(logic [31:0] pc, logic [1:0] f,
                                            logic [25:0] ix, logic [15:0] of,
                                            logic [31:0] rv);
      longint t;
      case (f)
         2'd0: t = longint'(pc) + 4;
         2'd1: t = longint'(ix) * 4;
         2'd2: t = longint'(pc) + longint'($signed(of)) * 4;
         default: t = longint'(rv);
      endcase
      return 32'h0400_1000 + 32'(t % 4096 < 0 ? t % 4096 + 4096 : t % 4096);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle of inputs at the falling edge, then compare after the rising edge
   task automatic step(string req, logic [31:0] pc, logic [1:0] f, logic lk,
                       logic [4:0] sel, logic [25:0] ix, logic [15:0] of,
                       logic [31:0] rv);
      @(negedge clk);
      cur_pc = pc; flow = f; do_link = lk; link_sel = sel;
      imm_index = ix; imm_offset = of; reg_val = rv;
      e_pc  = model_pc(pc, f, ix, of, rv);
      e_we  = lk && (f != 2'd0);
      e_idx = sel;
      e_val = pc + 32'd4;
      @(posedge clk);
      #2;
      // R8: result appears after exactly one edge
      check({req, " R8 pc"}, next_pc, e_pc);
      check({req, " R7 we"}, {31'd0, link_we}, {31'd0, e_we});
      if (e_we) begin
         check({req, " R7 idx"}, {27'd0, link_idx}, {27'd0, e_idx});
         check({req, " R7 val"}, link_val, e_val);
      end
      // R2
      check({req, " R2 hi"}, {12'd0, next_pc[31:12]}, 32'h0000_4001);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check("R1 reset pc", next_pc, 32'h0400_1000);
      check("R1 reset we", {31'd0, link_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      // R1 first cycle after release: inputs were zero, flow 0 from pc 0 gives base+4
      check("R1 post-release we", {31'd0, link_we}, 32'd0);

      // R3 sequential, including wrap at top of window
      step("R3 seq",      32'h0400_1010, 2'd0, 1'b0, 5'd0,  26'd0, 16'd0, 32'd0);
      step("R3 seq wrap", 32'h0400_1FFC, 2'd0, 1'b1, 5'd31, 26'd0, 16'd0, 32'd0);
      // R4 absolute
      step("R4 abs",      32'h0400_1000, 2'd1, 1'b0, 5'd0,  26'h123, 16'd0, 32'd0);
      step("R4 abs ones", 32'h0400_1000, 2'd1, 1'b1, 5'd31, 26'h3FF_FFFF, 16'd0, 32'd0);
      // R5 relative, forward and backward wrap
      step("R5 rel fwd",  32'h0400_1100, 2'd2, 1'b0, 5'd0,  26'd0, 16'h0010, 32'd0);
      step("R5 rel neg",  32'h0400_1000, 2'd2, 1'b1, 5'd9,  26'd0, 16'hFFFF, 32'd0);
      step("R5 rel big",  32'h0400_1FF0, 2'd2, 1'b0, 5'd0,  26'd0, 16'h7FFF, 32'd0);
      // R6 register, upper bits noisy
      step("R6 reg",      32'h0400_1000, 2'd3, 1'b0, 5'd0,  26'd0, 16'd0, 32'hDEAD_BEEF);
      step("R6 reg link", 32'h0400_1234, 2'd3, 1'b1, 5'd17, 26'd0, 16'd0, 32'hFFFF_F000);
      // R7 link value is unwrapped at window top
      step("R7 link top", 32'h0400_1FFC, 2'd1, 1'b1, 5'd3,  26'd5, 16'd0, 32'd0);
      // R2 noisy upper bits of cur_pc
      step("R2 noisy pc", 32'hFFFF_F7F8, 2'd0, 1'b0, 5'd0,  26'd0, 16'd0, 32'd0);

      for (int i = 0; i < 300; i++) begin
         step("rand", $urandom, 2'($urandom), 1'($urandom), 5'($urandom),
              26'($urandom), 16'($urandom), $urandom);
      end

      // R1 reset re-entry
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      check("R1 re-reset pc", next_pc, 32'h0400_1000);
      check("R1 re-reset we", {31'd0, link_we}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule